// File: doc/BRIEF.md
# Infrared Carrier Demodulator with Glitch Filter

This block turns the raw output of an infrared photodiode, which carries a burst-modulated carrier, into a clean mark/space level for a pulse-width capture stage downstream. A programmable divider derives a slow receive tick from the reference clock. A valid carrier is defined as 16 ticks per period. Each rising carrier edge is checked against a tolerance window around that period. The output declares a mark only while edges keep arriving inside that window. It returns to space once the late limit passes with no edge.

A minimum-width filter on the reference clock follows the carrier checker. It removes level pulses shorter than a programmed count of reference clocks, and a count of zero bypasses it. When demodulation is off, the synchronised raw input goes straight to the filter, so the block can also serve receivers that deliver an already demodulated envelope.

Top module: `ir_carrier_demod`

## Requirements
- R1: After reset, and until the input produces one, `level_out` is 0 (space).
- R2: The receive tick fires once every `clk_div`+1 reference clocks. Carrier intervals are measured in these ticks, so with `clk_div`=1 a 32-clock carrier period is valid and a 16-clock period is not.
- R3: `win_sel` bit 0 selects the early tolerance: 0 gives 3 ticks and 1 gives 4. Bit 1 selects the late tolerance in the same way. An interval between rising edges is valid when it lies from 16 minus the early tolerance to 16 plus the late tolerance, limits included.
- R4: With demodulation on, mark is declared once two consecutive valid intervals have been seen, which takes three rising edges. Two edges alone never give a mark.
- R5: An edge that comes earlier than the early limit is noise. It becomes the new reference and clears the count of valid intervals, so two further valid intervals are needed before mark.
- R6: When no rising edge arrives within 16 plus the late tolerance ticks of the previous one, the output returns to space. A carrier whose intervals are all too long never gives a mark.
- R7: With `demod_en` = 0, the synchronised raw level is passed to the filter unchanged.
- R8: With `min_width` = N > 0, a level pulse shorter than N reference clocks does not appear at `level_out`.
- R9: With `min_width` = N > 0, a level held for N or more reference clocks does appear at `level_out`.
- R10: With `min_width` = 0, the filter is bypassed, and a single-clock pulse on the input appears at `level_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_raw | input | 1 | Raw photodiode level (asynchronous) |
| demod_en | input | 1 | 1: check the carrier; 0: pass the raw level through |
| clk_div | input | 16 | Receive tick divider; tick rate = reference / (clk_div+1) |
| win_sel | input | 2 | Bit 0: early tolerance 3/4 ticks; bit 1: late tolerance 3/4 ticks |
| min_width | input | 16 | Minimum accepted pulse width in reference clocks; 0 bypasses the filter |
| level_out | output | 1 | Filtered level, 1 = mark |

## Verification
A wrong tick count or a misplaced window limit shows up as a mark that appears, or fails to appear, for a carrier one tick inside or outside the tolerance. The effect reaches `level_out` four reference clocks after the third rising edge. A stuck valid-interval count or a timeout that never fires leaves `level_out` high long after the carrier stops. A filter counter that does not clear lets a train of short glitches build up into a false level change. Sweeping the glitch width around `min_width` catches this within one pulse.

// File: rtl/irdm_pkg.sv
// Shared types and helpers for the infrared carrier demodulator.
// Assumes the window select code is two independent bits, early and late.
package irdm_pkg;

    // Tolerance window around the nominal 16-tick carrier period.
    typedef enum logic [1:0] {
        WIN_E3_L3 = 2'd0,
        WIN_E4_L3 = 2'd1,
        WIN_E3_L4 = 2'd2,
        WIN_E4_L4 = 2'd3
    } irdm_win_e;

    // Widest tolerance any window code can select.
    localparam int unsigned TOL_MAX = 4;

    // Early tolerance in ticks for a window code.
    function automatic logic [2:0] early_ticks(input irdm_win_e w);
        return w[0] ? 3'd4 : 3'd3;
    endfunction

    // Late tolerance in ticks for a window code.
    function automatic logic [2:0] late_ticks(input irdm_win_e w);
        return w[1] ? 3'd4 : 3'd3;
    endfunction

endpackage

// File: rtl/irdm_tick_gen.sv
// Receive tick generator: one-cycle pulse every (div_i+1) reference clocks.
// Assumes div_i is quasi-static; a new value takes effect on the next reload.
module irdm_tick_gen #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_q;

    assign tick_o = (cnt_q == '0);

    // Down-counter that reloads from the divider when it reaches zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick_o)
            cnt_q <= div_i;
        else
            cnt_q <= cnt_q - 1'b1;
    end

    // R2: a non-zero divider never yields ticks on adjacent clocks.
    a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && div_i != '0) |=> !tick_o);

endmodule

// File: rtl/irdm_edge_window.sv
// Carrier edge window checker. Measures ticks between rising carrier edges,
// declares mark after two consecutive in-window intervals, treats early
// edges as noise and drops mark when the late limit expires.
// Assumes edge_i is a one-clock pulse per synchronised rising edge.
module irdm_edge_window
    import irdm_pkg::*;
#(
    parameter int unsigned PERIOD = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       edge_i,
    input  logic [1:0] win_i,
    output logic       mark_o
);

    localparam int unsigned CNT_W = $clog2(PERIOD + TOL_MAX + 1);
    localparam logic [CNT_W:0] BASE = (CNT_W+1)'(PERIOD);

    irdm_win_e        win;
    logic [CNT_W-1:0] since_q;
    logic             have_ref_q;
    logic             one_ok_q;
    logic             mark_q;
    logic [CNT_W:0]   elapsed;
    logic [CNT_W:0]   lim_lo;
    logic [CNT_W:0]   lim_hi;

    assign win    = irdm_win_e'(win_i);
    assign mark_o = mark_q;

    // Window limits and the interval that ends on this clock.
    always_comb begin
        lim_lo  = BASE - {{(CNT_W-2){1'b0}}, early_ticks(win)};
        lim_hi  = BASE + {{(CNT_W-2){1'b0}}, late_ticks(win)};
        elapsed = {1'b0, since_q} + {{CNT_W{1'b0}}, tick_i};
    end

    // Interval classification, valid-interval tracking and timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q    <= '0;
            have_ref_q <= 1'b0;
            one_ok_q   <= 1'b0;
            mark_q     <= 1'b0;
        end else if (edge_i) begin
            since_q    <= '0;
            have_ref_q <= 1'b1;
            if (!have_ref_q) begin
                one_ok_q <= 1'b0;
            end else if (elapsed < lim_lo) begin
                one_ok_q <= 1'b0;
            end else if (elapsed > lim_hi) begin
                one_ok_q <= 1'b0;
                mark_q   <= 1'b0;
            end else begin
                one_ok_q <= 1'b1;
                if (one_ok_q)
                    mark_q <= 1'b1;
            end
        end else if (tick_i && have_ref_q) begin
            if (since_q == lim_hi[CNT_W-1:0]) begin
                since_q    <= '0;
                have_ref_q <= 1'b0;
                one_ok_q   <= 1'b0;
                mark_q     <= 1'b0;
            end else begin
                since_q <= since_q + 1'b1;
            end
        end
    end

    // R4: mark only rises as the result of a carrier edge.
    a_r4_mark_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mark_o) |-> $past(edge_i));

    // R6: mark only falls when a tick has moved time past the late limit.
    a_r6_drop_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mark_o) |-> $past(tick_i));

    // R3: the tick count never runs beyond the widest late limit.
    a_r3_since_bound: assert property (@(posedge clk) disable iff (!rst_n)
        since_q <= CNT_W'(PERIOD + TOL_MAX));

    // R4: a mark always stands on a reference edge.
    a_r4_mark_has_ref: assert property (@(posedge clk) disable iff (!rst_n)
        mark_o |-> have_ref_q);

endmodule

// File: rtl/irdm_glitch_filter.sv
// Minimum-width level filter on the reference clock. The output takes a new
// level only after the input has held it for min_i consecutive clocks;
// min_i == 0 makes the filter a single register stage.
// Assumes min_i changes only while the input is steady.
module irdm_glitch_filter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_i,
    input  logic [CNT_W-1:0] min_i,
    output logic             out_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_nxt;
    logic             out_q;

    assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
    assign out_o   = out_q;

    // Count clocks of disagreement and commit once the count is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
            cnt_q <= '0;
        end else if (min_i == '0) begin
            out_q <= in_i;
            cnt_q <= '0;
        end else if (in_i == out_q) begin
            cnt_q <= '0;
        end else if (cnt_nxt >= {1'b0, min_i}) begin
            out_q <= in_i;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R10: a zero count follows the input one clock later.
    a_r10_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (min_i == '0) |=> (out_o == $past(in_i)));

    // R8: an input that agrees with the output never changes it.
    a_r8_hold_when_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (in_i == out_o) |=> $stable(out_o));

endmodule

// File: rtl/ir_carrier_demod.sv
// Top of the infrared carrier demodulator: synchronises the raw input,
// detects rising carrier edges, checks them against the tick window and
// passes either the mark level or the raw level through the glitch filter.
// Assumes rx_raw is asynchronous to clk; configuration inputs are quasi-static.
module ir_carrier_demod #(
    parameter int unsigned DIV_W       = 16,
    parameter int unsigned FLT_W       = 16,
    parameter int unsigned PERIOD      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_raw,
    input  logic             demod_en,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [1:0]       win_sel,
    input  logic [FLT_W-1:0] min_width,
    output logic             level_out
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   rx_s;
    logic                   rise;
    logic                   tick;
    logic                   mark;
    logic                   flt_in;

    // First synchroniser stage samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q[0] <= 1'b0;
        else
            sync_q[0] <= rx_raw;
    end

    // Remaining synchroniser stages.
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n)
                sync_q[i] <= 1'b0;
            else
                sync_q[i] <= sync_q[i-1];
        end
    end

    assign rx_s = sync_q[SYNC_STAGES-1];

    // Previous synchronised level for rising edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= rx_s;
    end

    assign rise   = rx_s & ~prev_q;
    assign flt_in = demod_en ? mark : rx_s;

    irdm_tick_gen #(
        .DIV_W (DIV_W)
    ) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_i  (clk_div),
        .tick_o (tick)
    );

    irdm_edge_window #(
        .PERIOD (PERIOD)
    ) win_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .edge_i (rise),
        .win_i  (win_sel),
        .mark_o (mark)
    );

    irdm_glitch_filter #(
        .CNT_W (FLT_W)
    ) flt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  (flt_in),
        .min_i (min_width),
        .out_o (level_out)
    );

    // R7: with demodulation off and no filter, the output trails the synchroniser.
    a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (!demod_en && min_width == '0) |=> (level_out == $past(rx_s)));

    // R5: an edge is a one-clock event.
    a_r5_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: tb/ir_carrier_demod_tb_top.sv
module ir_carrier_demod_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_raw;
    logic        demod_en;
    logic [15:0] clk_div;
    logic [1:0]  win_sel;
    logic [15:0] min_width;
    logic        level_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit seen_hi;
    bit seen_lo;

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_carrier_demod dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_raw    (rx_raw),
        .demod_en  (demod_en),
        .clk_div   (clk_div),
        .win_sel   (win_sel),
        .min_width (min_width),
        .level_out (level_out)
    );

    // Expected mark decision for a steady carrier, from R2/R3.
    function automatic bit exp_mark(input logic [1:0] w, input int gap, input int dv);
        int ticks = gap / (dv + 1);
        int lo = 16 - (w[0] ? 4 : 3);
        int hi = 16 + (w[1] ? 4 : 3);
        return (ticks >= lo) && (ticks <= hi);
    endfunction

    // Expected visibility of a pulse of g clocks through a filter of n, from R8-R10.
    function automatic bit exp_pass(input int g, input int n);
        return (n == 0) || (g >= n);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance n clocks, sampling the output at each falling edge.
    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (level_out) seen_hi = 1'b1;
            else           seen_lo = 1'b1;
        end
    endtask

    // Send n rising edges spaced by gap clocks; high phase of 5 clocks.
    // Returns whether a mark was seen until 4 clocks after the last edge.
    task automatic carrier(input int n, input int gap, output bit saw);
        seen_hi = 1'b0;
        for (int k = 0; k < n; k++) begin
            rx_raw = 1'b1;
            if (k == n - 1) begin
                cyc(4);
            end else begin
                cyc(5);
                rx_raw = 1'b0;
                cyc(gap - 5);
            end
        end
        saw = seen_hi;
        cyc(1);
        rx_raw = 1'b0;
    endtask

    // One carrier test: idle, train, mark check, then timeout check (R6).
    task automatic carrier_case(input logic [1:0] w, input int gap, input int dv,
                                input string req);
        bit saw;
        bit e;
        win_sel = w;
        clk_div = 16'(dv);
        cyc(50 * (dv + 1));
        carrier(5, gap, saw);
        e = exp_mark(w, gap, dv);
        check(saw == e, req, int'(saw), int'(e));
        cyc(30 * (dv + 1));
        check(level_out == 1'b0, "R6", int'(level_out), 0);
    endtask

    initial begin
        bit saw;
        int unsigned seed;
        seed = $urandom(32'h1D2C_0A55);
        rst_n     = 1'b0;
        rx_raw    = 1'b0;
        demod_en  = 1'b1;
        clk_div   = 16'd0;
        win_sel   = 2'd0;
        min_width = 16'd0;
        cyc(4);
        check(level_out == 1'b0, "R1", int'(level_out), 0);
        rst_n = 1'b1;
        cyc(10);
        check(level_out == 1'b0, "R1", int'(level_out), 0);

        // R4: two edges are not enough, three are.
        carrier(2, 16, saw);
        check(saw == 1'b0, "R4", int'(saw), 0);
        cyc(50);
        carrier(3, 16, saw);
        check(saw == 1'b1, "R4", int'(saw), 1);
        cyc(50);

        // R3: window limits for every code, at and beyond each bound.
        carrier_case(2'd0, 13, 0, "R3");
        carrier_case(2'd0, 12, 0, "R3");
        carrier_case(2'd0, 19, 0, "R3");
        carrier_case(2'd0, 20, 0, "R6");
        carrier_case(2'd1, 12, 0, "R3");
        carrier_case(2'd1, 11, 0, "R3");
        carrier_case(2'd2, 20, 0, "R3");
        carrier_case(2'd2, 21, 0, "R6");
        carrier_case(2'd3, 12, 0, "R3");
        carrier_case(2'd3, 20, 0, "R3");

        // R2: divided tick, 32 clocks = 16 ticks, 16 clocks = 8 ticks.
        carrier_case(2'd0, 32, 1, "R2");
        carrier_case(2'd0, 16, 1, "R2");
        clk_div = 16'd0;
        win_sel = 2'd0;
        cyc(60);

        // R5: gaps 16, 12 (noise), 16 give no mark; one more 16 gives mark.
        seen_hi = 1'b0;
        rx_raw = 1'b1; cyc(5); rx_raw = 1'b0; cyc(11);
        rx_raw = 1'b1; cyc(5); rx_raw = 1'b0; cyc(7);
        rx_raw = 1'b1; cyc(5); rx_raw = 1'b0; cyc(11);
        rx_raw = 1'b1; cyc(5);
        check(seen_hi == 1'b0, "R5", int'(seen_hi), 0);
        rx_raw = 1'b0; cyc(11);
        rx_raw = 1'b1; cyc(5);
        check(level_out == 1'b1, "R5", int'(level_out), 1);
        rx_raw = 1'b0;
        cyc(40);

        // Random carriers against the window model (R3).
        for (int it = 0; it < 20; it++) begin
            logic [1:0] w = 2'($urandom_range(0, 3));
            int g = int'($urandom_range(10, 22));
            carrier_case(w, g, 0, "R3");
        end

        // Filter tests with demodulation off (R7-R10).
        demod_en = 1'b0;
        min_width = 16'd0;
        rx_raw = 1'b1;
        cyc(6);
        check(level_out == 1'b1, "R7", int'(level_out), 1);
        rx_raw = 1'b0;
        cyc(6);
        check(level_out == 1'b0, "R7", int'(level_out), 0);
        rx_raw = 1'b1;
        cyc(1);
        rx_raw = 1'b0;
        seen_hi = 1'b0;
        cyc(6);
        check(seen_hi == 1'b1, "R10", int'(seen_hi), 1);

        for (int it = 0; it < 40; it++) begin
            logic lvl = 1'($urandom_range(0, 1));
            int n = int'($urandom_range(1, 12));
            int g;
            bit e;
            bit saw_chg;
            if (it == 0)      g = n - 1;
            else if (it == 1) g = n;
            else              g = int'($urandom_range(1, 2 * n));
            if (g == 0) g = 1;
            rx_raw = lvl;
            cyc(n + 8);
            min_width = 16'(n);
            cyc(2);
            check(level_out == lvl, "R9", int'(level_out), int'(lvl));
            seen_hi = 1'b0;
            seen_lo = 1'b0;
            rx_raw = ~lvl;
            cyc(g);
            rx_raw = lvl;
            cyc(2 * n + 8);
            saw_chg = lvl ? seen_lo : seen_hi;
            e = exp_pass(g, n);
            check(saw_chg == e, e ? "R9" : "R8", int'(saw_chg), int'(e));
            min_width = 16'd0;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule